// File: doc/BRIEF.md
# CCD Line Black-Level Clamp

This block sits on the digitized pixel stream of a single CCD output register, one sample per pixel clock, and removes the black level from each line. A line strobe accompanies the first sample of every line and a frame strobe accompanies the first sample of every frame. The block tracks each sample's position along the line and sorts it into one of four groups. The first group is the horizontal register's leading dummy phases. Next comes the shielded dark reference column block. Then come the light-sensitive buffer columns, and last the active columns. Any samples after the active columns are overclock samples and are discarded.

The black level of a line is the mean of the dark reference columns of that line. The outermost column on each side of the dark block is left out, because light can leak into those two columns. The mean is computed as an exact floor division by the number of inner dark columns, using a multiply by a fixed-point reciprocal. The black level is subtracted from every active sample of the same line, with the result held at zero when it would go negative. If a line ends before its inner dark window is complete, the black level from the previous line stays in force.

A row tracker places each line within the frame. The frame opens with dummy rows, then shielded dark rows, then image rows, then dark rows again, and closes with dummy rows. Only image rows produce corrected output. Dark rows are never treated as a black reference. The line and segment tracker uses the states SEG_IDLE, SEG_DUMMY, SEG_DARK, SEG_BUFFER and SEG_ACTIVE. A line strobe forces SEG_DUMMY. Each of the next four states is entered when the previous segment's last sample has arrived, in the order dummy, dark, buffer, active, idle. The row tracker uses the states ROW_IDLE, ROW_TOP_DUMMY, ROW_TOP_DARK, ROW_IMAGE, ROW_BOT_DARK and ROW_BOT_DUMMY. A frame strobe forces ROW_TOP_DUMMY. After that, each line strobe either counts one more row within the current state or, after that state's last row, moves to the next state in the listed order, ending in ROW_IDLE.

Top module: `ccd_black_clamp`

## Requirements
- R1: After reset, pix_out_valid is low and black_level is 0.
- R2: A sample with line_start high is dummy phase 0 of a new line. The first DUMMY_COLS (11) samples of each line never reach the output and never change black_level.
- R3: The next DARK_COLS (22) samples are dark reference, line indices 11 to 32. Only the inner 20 (indices 12 to 31) count toward the black level; index 11 and index 32 are excluded.
- R4: Once the last inner dark sample (index 31) of a line has arrived, black_level becomes floor(sum of the 20 inner samples / 20). It changes within 2 clock cycles and before the first active sample of that line.
- R5: The BUFFER_COLS (12) samples that follow the dark block, indices 33 to 44, produce no output and do not change black_level.
- R6: The ACTIVE_COLS samples that follow the buffer block produce an output when they fall in an image row. One cycle after each such input sample, pix_out_valid is high and pix_out equals max(sample - black_level, 0).
- R7: Samples that arrive after the active block and before the next line_start produce no output.
- R8: If a line_start arrives before the sample at index 31, black_level keeps its previous value.
- R9: A frame_start line is a top dummy row. It is followed by DARK_ROWS dark rows, IMAGE_ROWS image rows, DARK_ROWS dark rows and DUMMY_ROWS bottom dummy rows. Lines in dummy rows, in dark rows, before the first frame_start, and after the bottom dummy rows produce no output.
- R10: Cycles with sample_valid low neither advance the column position nor produce output, so a stalled line is classified the same as an unbroken one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | pix_in carries a sample this cycle |
| line_start | input | 1 | This sample is the first of a line |
| frame_start | input | 1 | This sample is the first of a frame |
| pix_in | input | DATA_W | Unsigned digitized sample |
| pix_out | output | DATA_W | Black-corrected active sample |
| pix_out_valid | output | 1 | pix_out holds a corrected image sample |
| black_level | output | DATA_W | Black level currently applied |

## Verification
The assertions assume that line_start is only raised together with sample_valid, and that frame_start is only raised together with line_start. They also assume that the buffer block is long enough to cover the two-cycle black-level pipeline. The stimulus tasks raise a line strobe only on the first valid sample of a line and a frame strobe only on a line strobe. Stall cycles are inserted only between samples, never on a strobe. All column counts stay at their defaults, so every line passes through the full buffer block before its active samples.

// File: rtl/ccd_clamp_pkg.sv
package ccd_clamp_pkg;

    typedef enum logic [2:0] {
        SEG_IDLE,
        SEG_DUMMY,
        SEG_DARK,
        SEG_BUFFER,
        SEG_ACTIVE
    } seg_e;

    typedef enum logic [2:0] {
        ROW_IDLE,
        ROW_TOP_DUMMY,
        ROW_TOP_DARK,
        ROW_IMAGE,
        ROW_BOT_DARK,
        ROW_BOT_DUMMY
    } row_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clamp_col_fsm.sv
module clamp_col_fsm
    import ccd_clamp_pkg::*;
#(
    parameter int DUMMY_COLS  = 11,
    parameter int DARK_COLS   = 22,
    parameter int DARK_EDGE   = 1,
    parameter int BUFFER_COLS = 12,
    parameter int ACTIVE_COLS = 3288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic line_start,
    output seg_e seg,
    output logic inner,
    output logic last_inner
);

    localparam int MAX_LEN = max2(max2(DUMMY_COLS, DARK_COLS), max2(BUFFER_COLS, ACTIVE_COLS));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam int IN_LO   = DARK_EDGE;
    localparam int IN_HI   = DARK_COLS - 1 - DARK_EDGE;

    seg_e             state_q, state_d, cur_state, nxt_state;
    logic [CNT_W-1:0] cnt_q, cnt_d, cur_cnt;
    logic             seg_last;

    // a line strobe places its own sample at dummy phase 0
    always_comb begin
        cur_state = line_start ? SEG_DUMMY : state_q;
        cur_cnt   = line_start ? '0 : cnt_q;
    end

    always_comb begin
        seg_last  = 1'b0;
        nxt_state = SEG_IDLE;
        unique case (cur_state)
            SEG_IDLE: begin
                seg_last  = 1'b0;
                nxt_state = SEG_IDLE;
            end
            SEG_DUMMY: begin
                seg_last  = (cur_cnt == CNT_W'(DUMMY_COLS - 1));
                nxt_state = SEG_DARK;
            end
            SEG_DARK: begin
                seg_last  = (cur_cnt == CNT_W'(DARK_COLS - 1));
                nxt_state = SEG_BUFFER;
            end
            SEG_BUFFER: begin
                seg_last  = (cur_cnt == CNT_W'(BUFFER_COLS - 1));
                nxt_state = SEG_ACTIVE;
            end
            SEG_ACTIVE: begin
                seg_last  = (cur_cnt == CNT_W'(ACTIVE_COLS - 1));
                nxt_state = SEG_IDLE;
            end
            default: begin
                seg_last  = 1'b0;
                nxt_state = SEG_IDLE;
            end
        endcase

        state_d = cur_state;
        cnt_d   = cur_cnt;
        if (valid && (cur_state != SEG_IDLE)) begin
            if (seg_last) begin
                state_d = nxt_state;
                cnt_d   = '0;
            end else begin
                cnt_d = cur_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        seg        = valid ? cur_state : SEG_IDLE;
        inner      = valid && (cur_state == SEG_DARK)
                     && (cur_cnt >= CNT_W'(IN_LO)) && (cur_cnt <= CNT_W'(IN_HI));
        last_inner = inner && (cur_cnt == CNT_W'(IN_HI));
    end

    AST_GAP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !line_start) |=> ($stable(state_q) && $stable(cnt_q))); // R10
    AST_STROBE_OPENS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && line_start) |=> (state_q == SEG_DUMMY || state_q == SEG_DARK)); // R2
    AST_IDLE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEG_IDLE && !line_start) |=> (state_q == SEG_IDLE)); // R7

endmodule

// File: rtl/clamp_row_fsm.sv
module clamp_row_fsm
    import ccd_clamp_pkg::*;
#(
    parameter int DUMMY_ROWS = 1,
    parameter int DARK_ROWS  = 22,
    parameter int IMAGE_ROWS = 4384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic frame_start,
    output logic image_row
);

    localparam int MAX_ROWS = max2(max2(DUMMY_ROWS, DARK_ROWS), IMAGE_ROWS);
    localparam int RCNT_W   = $clog2(MAX_ROWS + 1);

    row_e              row_q, cur_row, adv_row, nxt_row;
    logic [RCNT_W-1:0] rcnt_q, cur_cnt, adv_cnt;
    logic              row_last;

    always_comb begin
        row_last = 1'b0;
        nxt_row  = ROW_IDLE;
        unique case (row_q)
            ROW_IDLE: begin
                row_last = 1'b0;
                nxt_row  = ROW_IDLE;
            end
            ROW_TOP_DUMMY: begin
                row_last = (rcnt_q == RCNT_W'(DUMMY_ROWS - 1));
                nxt_row  = ROW_TOP_DARK;
            end
            ROW_TOP_DARK: begin
                row_last = (rcnt_q == RCNT_W'(DARK_ROWS - 1));
                nxt_row  = ROW_IMAGE;
            end
            ROW_IMAGE: begin
                row_last = (rcnt_q == RCNT_W'(IMAGE_ROWS - 1));
                nxt_row  = ROW_BOT_DARK;
            end
            ROW_BOT_DARK: begin
                row_last = (rcnt_q == RCNT_W'(DARK_ROWS - 1));
                nxt_row  = ROW_BOT_DUMMY;
            end
            ROW_BOT_DUMMY: begin
                row_last = (rcnt_q == RCNT_W'(DUMMY_ROWS - 1));
                nxt_row  = ROW_IDLE;
            end
            default: begin
                row_last = 1'b0;
                nxt_row  = ROW_IDLE;
            end
        endcase

        if (row_q == ROW_IDLE) begin
            adv_row = ROW_IDLE;
            adv_cnt = '0;
        end else if (row_last) begin
            adv_row = nxt_row;
            adv_cnt = '0;
        end else begin
            adv_row = row_q;
            adv_cnt = rcnt_q + RCNT_W'(1);
        end
    end

    always_comb begin
        if (frame_start) begin
            cur_row = ROW_TOP_DUMMY;
            cur_cnt = '0;
        end else if (line_start) begin
            cur_row = adv_row;
            cur_cnt = adv_cnt;
        end else begin
            cur_row = row_q;
            cur_cnt = rcnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= ROW_IDLE;
            rcnt_q <= '0;
        end else begin
            row_q  <= cur_row;
            rcnt_q <= cur_cnt;
        end
    end

    always_comb image_row = (cur_row == ROW_IMAGE);

    AST_ROW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(row_q)); // R9
    AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start); // R9
    AST_FRAME_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (row_q == ROW_TOP_DUMMY)); // R9

endmodule

// File: rtl/clamp_dark_avg.sv
module clamp_dark_avg #(
    parameter int DATA_W   = 14,
    parameter int NUM_DARK = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              inner,
    input  logic              last_inner,
    input  logic [DATA_W-1:0] pix,
    output logic [DATA_W-1:0] black
);

    localparam int NCLOG   = $clog2(NUM_DARK);
    localparam int SUM_W   = DATA_W + NCLOG;
    localparam int SHIFT   = SUM_W + NCLOG;
    localparam int RECIP_W = SHIFT - NCLOG + 2;
    localparam int PROD_W  = SUM_W + RECIP_W;
    localparam logic [63:0] RECIP64 =
        ((64'd1 << SHIFT) + 64'(NUM_DARK) - 64'd1) / 64'(NUM_DARK);
    localparam logic [RECIP_W-1:0] RECIP = RECIP_W'(RECIP64);

    logic [SUM_W-1:0]  acc_q, sum_q;
    logic              sum_rdy_q;
    logic [DATA_W-1:0] black_q;
    logic [PROD_W-1:0] prod;

    // ceiling reciprocal with SHIFT = SUM_W + log2 gives exact floor division
    always_comb prod = PROD_W'(sum_q) * PROD_W'(RECIP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            sum_q     <= '0;
            sum_rdy_q <= 1'b0;
            black_q   <= '0;
        end else begin
            if (line_start)
                acc_q <= '0;
            else if (inner)
                acc_q <= acc_q + SUM_W'(pix);
            sum_rdy_q <= last_inner;
            if (last_inner)
                sum_q <= acc_q + SUM_W'(pix);
            if (sum_rdy_q)
                black_q <= DATA_W'(prod >> SHIFT);
        end
    end

    assign black = black_q;

    AST_BLACK_ONLY_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_rdy_q |=> $stable(black_q)); // R8
    AST_FLOOR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sum_rdy_q |=> (64'(black_q) * 64'(NUM_DARK) <= 64'($past(sum_q)))); // R4
    AST_FLOOR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sum_rdy_q |=> ((64'(black_q) + 64'd1) * 64'(NUM_DARK) > 64'($past(sum_q)))); // R4

endmodule

// File: rtl/ccd_black_clamp.sv
module ccd_black_clamp
    import ccd_clamp_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int DUMMY_COLS  = 11,
    parameter int DARK_COLS   = 22,
    parameter int DARK_EDGE   = 1,
    parameter int BUFFER_COLS = 12,
    parameter int ACTIVE_COLS = 3288,
    parameter int DUMMY_ROWS  = 1,
    parameter int DARK_ROWS   = 22,
    parameter int IMAGE_ROWS  = 4384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic              line_start,
    input  logic              frame_start,
    input  logic [DATA_W-1:0] pix_in,
    output logic [DATA_W-1:0] pix_out,
    output logic              pix_out_valid,
    output logic [DATA_W-1:0] black_level
);

    localparam int NUM_DARK = DARK_COLS - 2 * DARK_EDGE;

    seg_e              seg;
    logic              inner, last_inner, image_row, emit;
    logic [DATA_W-1:0] black, diff;

    clamp_col_fsm #(
        .DUMMY_COLS (DUMMY_COLS),
        .DARK_COLS  (DARK_COLS),
        .DARK_EDGE  (DARK_EDGE),
        .BUFFER_COLS(BUFFER_COLS),
        .ACTIVE_COLS(ACTIVE_COLS)
    ) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (sample_valid),
        .line_start(line_start),
        .seg       (seg),
        .inner     (inner),
        .last_inner(last_inner)
    );

    clamp_row_fsm #(
        .DUMMY_ROWS(DUMMY_ROWS),
        .DARK_ROWS (DARK_ROWS),
        .IMAGE_ROWS(IMAGE_ROWS)
    ) u_row (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .frame_start(frame_start),
        .image_row  (image_row)
    );

    clamp_dark_avg #(
        .DATA_W  (DATA_W),
        .NUM_DARK(NUM_DARK)
    ) u_avg (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .inner     (inner),
        .last_inner(last_inner),
        .pix       (pix_in),
        .black     (black)
    );

    always_comb begin
        emit = (seg == SEG_ACTIVE) && image_row;
        diff = (pix_in > black) ? (pix_in - black) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out_valid <= 1'b0;
            pix_out       <= '0;
        end else begin
            pix_out_valid <= emit;
            if (emit)
                pix_out <= diff;
        end
    end

    assign black_level = black;

    AST_STROBE_HAS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> sample_valid); // R2
    AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out_valid |-> $past(sample_valid)); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out_valid |-> (pix_out <= $past(pix_in))); // R6
    AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> !pix_out_valid); // R10

endmodule

// File: tb/ccd_black_clamp_tb.sv
`timescale 1ns/1ps
module ccd_black_clamp_tb;

    localparam int DW     = 14;
    localparam int NDUM   = 11;
    localparam int NDARK  = 22;
    localparam int NBUF   = 12;
    localparam int NACT   = 6;
    localparam int NOVER  = 2;
    localparam int POISON = 16383;
    localparam int NV     = 6;
    // dark_base, act_base, act_step, stall_every
    localparam int TBL [NV][4] = '{
        '{100,   500,    37,    0},
        '{2000,  1990,   5,     0},
        '{0,     0,      1,     3},
        '{16371, 16383,  -1,    0},
        '{700,   16383,  -3000, 2},
        '{50,    60,     0,     0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_valid = 1'b0;
    logic          line_start = 1'b0;
    logic          frame_start = 1'b0;
    logic [DW-1:0] pix_in = '0;
    logic [DW-1:0] pix_out;
    logic          pix_out_valid;
    logic [DW-1:0] black_level;

    int    checks = 0;
    int    failures = 0;
    int    exp_black = 0;
    bit    pend_v = 1'b0;
    int    pend_x = 0;
    string pend_tag = "R1";

    always #2.5 clk = ~clk;

    ccd_black_clamp #(
        .ACTIVE_COLS(NACT),
        .DUMMY_ROWS (1),
        .DARK_ROWS  (2),
        .IMAGE_ROWS (3)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .line_start   (line_start),
        .frame_start  (frame_start),
        .pix_in       (pix_in),
        .pix_out      (pix_out),
        .pix_out_valid(pix_out_valid),
        .black_level  (black_level)
    );

    function automatic int clip(input int v);
        return (v < 0) ? 0 : ((v > POISON) ? POISON : v);
    endfunction

    task automatic step(input bit v, input int val, input bit ls, input bit fs,
                        input bit ev, input int ex, input string tag);
        @(negedge clk);
        checks++;
        if (pend_v) begin
            if (!pix_out_valid || (pix_out != pend_x[DW-1:0])) begin
                failures++;
                $display("FAIL %s: pix_out=%0d valid=%0b expected=%0d valid=1",
                         pend_tag, pix_out, pix_out_valid, pend_x);
            end
        end else if (pix_out_valid) begin
            failures++;
            $display("FAIL %s: pix_out valid=1 (value %0d) expected valid=0",
                     pend_tag, pix_out);
        end
        sample_valid = v;
        pix_in       = val[DW-1:0];
        line_start   = ls;
        frame_start  = fs;
        pend_v       = ev;
        pend_x       = ex;
        pend_tag     = tag;
    endtask

    task automatic check_black(input int ex, input string tag);
        checks++;
        if (black_level != ex[DW-1:0]) begin
            failures++;
            $display("FAIL %s: black_level=%0d expected=%0d", tag, black_level, ex);
        end
    endtask

    // cut < 0 sends a whole line; otherwise only the first cut samples
    task automatic send_line(input int dark_base, input int act_base, input int act_step,
                             input int stall, input bit fs, input bit img, input int cut);
        int    sum;
        int    total;
        int    val;
        bit    ev;
        int    ex;
        string tag;
        sum   = 0;
        total = NDUM + NDARK + NBUF + NACT + NOVER;
        for (int n = 0; n < total; n++) begin
            if (cut >= 0 && n >= cut) break;
            ev  = 1'b0;
            ex  = 0;
            val = POISON;
            tag = "R7";
            if (n < NDUM) begin
                tag = "R2";
            end else if (n < NDUM + NDARK) begin
                int d;
                d   = n - NDUM;
                tag = "R3";
                if (d != 0 && d != NDARK - 1) begin
                    val = dark_base + ((d - 1) * 7) % 13;
                    sum += val;
                end
            end else if (n < NDUM + NDARK + NBUF) begin
                tag = "R5";
            end else if (n < NDUM + NDARK + NBUF + NACT) begin
                val = clip(act_base + (n - NDUM - NDARK - NBUF) * act_step);
                if (img) begin
                    ev  = 1'b1;
                    ex  = (val > exp_black) ? val - exp_black : 0;
                    tag = (stall > 0) ? "R10" : "R6";
                end else begin
                    tag = "R9";
                end
            end
            step(1'b1, val, n == 0, fs && (n == 0), ev, ex, tag);
            // window complete once the last inner dark sample is in
            if (n == NDUM + NDARK - 2) exp_black = sum / (NDARK - 2);
            if (stall > 0 && (n % stall) == stall - 1)
                step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, "R10");
        end
        for (int k = 0; k < 3; k++) step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, "R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pix_out_valid !== 1'b0 || black_level !== '0) begin
            failures++;
            $display("FAIL R1: valid=%0b black=%0d expected valid=0 black=0",
                     pix_out_valid, black_level);
        end

        // line before any frame: no output (R9), black still follows (R4)
        send_line(400, 9000, 11, 0, 1'b0, 1'b1 == 1'b0, -1);
        check_black(exp_black, "R4");

        for (int f = 0; f < 2; f++) begin
            send_line(9000, POISON, 0, 0, 1'b1, 1'b0, -1);
            check_black(exp_black, "R3 R4");
            for (int r = 0; r < 2; r++) begin
                send_line(300 + f * 10 + r, POISON, 0, 0, 1'b0, 1'b0, -1);
                check_black(exp_black, "R3 R4");
            end
            for (int r = 0; r < 3; r++) begin
                int e;
                e = f * 3 + r;
                send_line(TBL[e][0], TBL[e][1], TBL[e][2], TBL[e][3], 1'b0, 1'b1, -1);
                check_black(exp_black, "R3 R4");
            end
            for (int r = 0; r < 2; r++) begin
                send_line(5000, POISON, 0, 0, 1'b0, 1'b0, -1);
                check_black(exp_black, "R3 R4");
            end
            send_line(9000, POISON, 0, 0, 1'b0, 1'b0, -1);
            check_black(exp_black, "R3 R4");
        end

        // short line one sample before the window closes: black kept (R8)
        prev = exp_black;
        send_line(1234, 0, 0, 0, 1'b0, 1'b0, NDUM + NDARK - 2);
        check_black(prev, "R8");
        // a line ending right after the last inner dark sample updates it (R8 boundary)
        send_line(1234, 0, 0, 0, 1'b0, 1'b0, NDUM + NDARK - 1);
        check_black(exp_black, "R8");
        // the excluded trailing edge alone cannot change the level (R3)
        prev = exp_black;
        send_line(1234, 0, 0, 0, 1'b0, 1'b0, NDUM + NDARK);
        check_black(prev, "R3");

        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, "R10");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule